// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line in one private, direct-mapped cache that sits on a shared snooping bus. It serves local processor reads and writes. It issues bus transactions when a request cannot be completed locally. It also answers snooped traffic from peer caches: it reports that it holds a copy, it supplies dirty data, and it applies update broadcasts.

A line can be Modified, Owned, Exclusive, Shared or Invalid. The Owned state allows dirty data to be shared among caches without writing it to memory. When this cache writes an Owned line, it pushes the new word to the sharers instead of invalidating their copies. Each line stores one data word. Memory and the bus arbiter are outside the block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snooped read reports no copy, and any local access misses.
- R2: A local read that hits a line in M, O, E or S raises `cpu_ready` in the same cycle with the stored word and requests no bus transaction.
- R3: A local read miss issues a bus read (`bus_cmd` 0). When it is granted, the line fills with `bus_rdata`. The line becomes Exclusive if `bus_shared` is low at the grant, and Shared otherwise.
- R4: A local write to an Exclusive line becomes Modified with no bus traffic. A write to a Modified line also needs no bus traffic. A write to a Shared line issues an invalidate (`bus_cmd` 2), and a write miss issues a read-for-ownership (`bus_cmd` 1). In both of these cases the line ends Modified and holds the written word.
- R5: A local write to an Owned line issues an update broadcast (`bus_cmd` 4) that carries the new word. The line stays Owned and keeps the new word.
- R6: A snooped read (`snp_cmd` 0) that hits a line asserts `snp_shared`. On a Modified line it supplies the data on `snp_rdata` with `snp_supply` high, and the line moves to Owned. An Owned line supplies the data and stays Owned. An Exclusive line moves to Shared and supplies nothing. A Shared line supplies nothing.
- R7: A snooped probe write (`snp_cmd` 1) that hits any valid line makes that line Invalid. A Modified or Owned line supplies its data in that cycle.
- R8: A snooped update (`snp_cmd` 2) that hits a Shared line replaces its word, and the line stays Shared.
- R9: A miss whose victim is Modified or Owned first writes the victim back (`bus_cmd` 3) with the victim's address and word, and the line becomes Invalid. The refill follows. A clean victim is dropped with no write-back. The line index is the low `IDX_W` address bits, and the tag is the rest.
- R10: Only one bus transaction is pending at a time. `bus_req` and `cpu_ready` stay as they are while the grant is withheld, and the request completes only after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Local request present, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Local request address |
| cpu_wdata | input | DATA_W | Local write word |
| cpu_ready | output | 1 | Local request completes this cycle |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 3 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back, 4 update |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Word for write-back or update |
| bus_gnt | input | 1 | Transaction granted and completed this cycle |
| bus_shared | input | 1 | Another cache holds the line (read fill) |
| bus_rdata | input | DATA_W | Fill word for read or read-for-ownership |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | 0 probe read, 1 probe write, 2 update |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Word carried by a snooped update |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the data, so memory stays silent |
| snp_rdata | output | DATA_W | Supplied word |

## Verification
A wrong line state never shows up directly at the ports. It shows up the next time the line is touched. A line left valid, or dropped too early, turns a hit into a bus read, or a bus read into a hit, in the very cycle of the next local access. A wrong dirty state shows up at the next snoop or eviction: a supply is missing or extra, a write-back is lost, or the write leaves as an invalidate instead of an update. The directed scenarios therefore follow each state change with a snoop or local access that separates the candidate states. A Shared line is told apart from an Exclusive one by whether a write goes out on the bus. An Owned line is told apart from a Shared one by whether it supplies data.

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_rdata
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [2:0] BC_RD = 3'd0, BC_RFO = 3'd1, BC_INV = 3'd2, BC_WB = 3'd3, BC_UPD = 3'd4;
  localparam logic [1:0] SN_RD = 2'd0, SN_WR = 2'd1, SN_UPD = 2'd2;

  logic [2:0]        st_q  [DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [DATA_W-1:0] dat_q [DEPTH];

  logic [IDX_W-1:0] l_idx, s_idx;
  logic [TAG_W-1:0] l_tag, s_tag;
  logic [2:0]       l_st, s_st;
  logic             l_hit, s_hit, l_dirty, l_silent, bus_fire;

  assign l_idx   = cpu_addr[IDX_W-1:0];
  assign l_tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign l_st    = st_q[l_idx];
  assign l_hit   = (l_st != ST_I) && (tag_q[l_idx] == l_tag);
  assign l_dirty = (l_st == ST_M) || (l_st == ST_O);

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_st  = st_q[s_idx];
  assign s_hit = (s_st != ST_I) && (tag_q[s_idx] == s_tag);

  assign bus_fire  = bus_req && bus_gnt;
  assign l_silent  = cpu_valid && cpu_write && l_hit && (l_st == ST_M || l_st == ST_E);
  assign cpu_rdata = dat_q[l_idx];

  assign snp_shared = snp_valid && s_hit;
  assign snp_supply = snp_shared && (snp_cmd != SN_UPD) && (s_st == ST_M || s_st == ST_O);
  assign snp_rdata  = dat_q[s_idx];

  always_comb begin
    bus_req   = 1'b0;
    bus_cmd   = BC_RD;
    bus_addr  = cpu_addr;
    bus_wdata = cpu_wdata;
    cpu_ready = 1'b0;
    if (cpu_valid) begin
      if (!l_hit && l_dirty) begin
        bus_req   = 1'b1;
        bus_cmd   = BC_WB;
        bus_addr  = {tag_q[l_idx], l_idx};
        bus_wdata = dat_q[l_idx];
      end else if (!cpu_write) begin
        cpu_ready = l_hit;
        bus_req   = !l_hit;
      end else if (l_hit && (l_st == ST_M || l_st == ST_E)) begin
        cpu_ready = 1'b1;
      end else begin
        bus_req   = 1'b1;
        cpu_ready = bus_gnt;
        if (!l_hit)              bus_cmd = BC_RFO;
        else if (l_st == ST_O)   bus_cmd = BC_UPD;
        else                     bus_cmd = BC_INV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ST_I;
    end else begin
      if (bus_fire) begin
        case (bus_cmd)
          BC_WB:          st_q[l_idx] <= ST_I;
          BC_RD:          st_q[l_idx] <= bus_shared ? ST_S : ST_E;
          BC_RFO, BC_INV: st_q[l_idx] <= ST_M;
          default:        ;
        endcase
      end else if (l_silent) begin
        st_q[l_idx] <= ST_M;
      end
      if (snp_valid && s_hit) begin
        if (snp_cmd == SN_WR)                         st_q[s_idx] <= ST_I;
        else if (snp_cmd == SN_RD && s_st == ST_M)    st_q[s_idx] <= ST_O;
        else if (snp_cmd == SN_RD && s_st == ST_E)    st_q[s_idx] <= ST_S;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (bus_fire) begin
      case (bus_cmd)
        BC_RD: begin
          tag_q[l_idx] <= l_tag;
          dat_q[l_idx] <= bus_rdata;
        end
        BC_RFO: begin
          tag_q[l_idx] <= l_tag;
          dat_q[l_idx] <= cpu_wdata;
        end
        BC_INV, BC_UPD: dat_q[l_idx] <= cpu_wdata;
        default: ;
      endcase
    end else if (l_silent) begin
      dat_q[l_idx] <= cpu_wdata;
    end
    if (snp_valid && s_hit && snp_cmd == SN_UPD && s_st == ST_S)
      dat_q[s_idx] <= snp_wdata;
  end
endmodule

// File: rtl/moesi_line_chk.sv
module moesi_line_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [2:0]        bus_cmd,
  input logic              bus_shared,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_shared,
  input logic [2:0]        l_st,
  input logic              l_hit,
  input logic [2:0]        s_st
);
  localparam logic [2:0] C_I = 3'd0, C_S = 3'd1, C_E = 3'd2, C_O = 3'd3, C_M = 3'd4;

  p_fill_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && bus_gnt && bus_cmd == 3'd0) && cpu_valid &&
     cpu_addr == $past(cpu_addr) && !$past(snp_valid))
    |-> l_hit && (l_st == ($past(bus_shared) ? C_S : C_E)));

  p_update_keeps_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && bus_gnt && bus_cmd == 3'd4) &&
     cpu_addr == $past(cpu_addr) && !$past(snp_valid))
    |-> l_st == C_O);

  p_mod_to_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && snp_cmd == 2'd0 && snp_shared && s_st == C_M) &&
     snp_addr == $past(snp_addr) && !$past(bus_req && bus_gnt))
    |-> s_st == C_O);

  p_probe_write_inval_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && snp_cmd == 2'd1 && snp_shared) &&
     snp_addr == $past(snp_addr) && !$past(bus_req && bus_gnt))
    |-> s_st == C_I);

  p_victim_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && bus_gnt && bus_cmd == 3'd3) &&
     cpu_addr == $past(cpu_addr) && !$past(snp_valid))
    |-> !l_hit && l_st == C_I);

  p_stall_until_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !cpu_ready);
endmodule

bind moesi_line_ctrl moesi_line_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_moesi_line_ctrl.sv
module tb_moesi_line_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        bus_req;
  logic [2:0]  bus_cmd;
  logic [7:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_gnt = 0, bus_shared = 0;
  logic [15:0] bus_rdata = 0;
  logic        snp_valid = 0;
  logic [1:0]  snp_cmd = 0;
  logic [7:0]  snp_addr = 0;
  logic [15:0] snp_wdata = 0;
  logic        snp_shared, snp_supply;
  logic [15:0] snp_rdata;

  moesi_line_ctrl dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [15:0] mem [256];
  int ncmd, ncyc;
  logic [2:0]  cmds  [4];
  logic [7:0]  caddr [4];
  logic [15:0] cdat  [4];
  logic [15:0] rd, sd;
  logic sh, sp;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                       input logic shr, input int gdelay, output logic [15:0] rdo);
    logic done = 0;
    int waited = 0;
    ncmd = 0; ncyc = 0; rdo = 'x;
    @(negedge clk);
    cpu_valid = 1; cpu_write = wr; cpu_addr = a; cpu_wdata = wd;
    while (!done && ncyc < 60) begin
      ncyc++;
      #1;
      if (cpu_ready) begin
        rdo = cpu_rdata; done = 1;
      end else if (bus_req) begin
        if (waited < gdelay) waited++;
        else begin
          if (ncmd < 4) begin
            cmds[ncmd] = bus_cmd; caddr[ncmd] = bus_addr; cdat[ncmd] = bus_wdata;
          end
          ncmd++;
          waited = 0;
          bus_gnt = 1; bus_shared = shr; bus_rdata = mem[bus_addr];
          if (bus_cmd == 3'd3) mem[bus_addr] = bus_wdata;
          #1;
          if (cpu_ready) begin rdo = cpu_rdata; done = 1; end
        end
      end
      @(posedge clk); #1;
      bus_gnt = 0; bus_shared = 0;
      if (!done) @(negedge clk);
    end
    cpu_valid = 0;
    if (!done) chk("R10 request completion", 0, 1);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                       output logic sho, output logic spo, output logic [15:0] sdo);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_wdata = d;
    #1;
    sho = snp_shared; spo = snp_supply; sdo = snp_rdata;
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 idle ready", cpu_ready, 0);
    chk("R1 idle bus_req", bus_req, 0);
    snoop(2'd0, 8'h10, 0, sh, sp, sd);
    chk("R1 no copy after reset", sh, 0);
  endtask

  task automatic t_exclusive;
    do_op(0, 8'h10, 0, 0, 0, rd);
    chk("R3 miss txn count", ncmd, 1);
    chk("R3 miss cmd read", cmds[0], 0);
    chk("R3 fill data", rd, 16'hA510);
    do_op(1, 8'h10, 16'hAAAA, 0, 0, rd);
    chk("R4 E write silent", ncmd, 0);
    do_op(0, 8'h10, 0, 0, 0, rd);
    chk("R2 hit no bus", ncmd, 0);
    chk("R2 hit data", rd, 16'hAAAA);
  endtask

  task automatic t_owned;
    snoop(2'd0, 8'h10, 0, sh, sp, sd);
    chk("R6 M shared", sh, 1);
    chk("R6 M supplies", sp, 1);
    chk("R6 M data", sd, 16'hAAAA);
    snoop(2'd0, 8'h10, 0, sh, sp, sd);
    chk("R6 O supplies", sp, 1);
    do_op(1, 8'h10, 16'hBBBB, 0, 0, rd);
    chk("R5 one txn", ncmd, 1);
    chk("R5 update cmd", cmds[0], 4);
    chk("R5 update data", cdat[0], 16'hBBBB);
    do_op(0, 8'h10, 0, 0, 0, rd);
    chk("R2 O hit no bus", ncmd, 0);
    chk("R5 new word kept", rd, 16'hBBBB);
    snoop(2'd0, 8'h10, 0, sh, sp, sd);
    chk("R5 stays owned supply", sp, 1);
    chk("R5 owned data", sd, 16'hBBBB);
  endtask

  task automatic t_evict_owned;
    do_op(0, 8'h14, 0, 1, 0, rd);
    chk("R9 txn count", ncmd, 2);
    chk("R9 write-back first", cmds[0], 3);
    chk("R9 victim addr", caddr[0], 8'h10);
    chk("R9 victim data", cdat[0], 16'hBBBB);
    chk("R9 memory updated", mem[8'h10], 16'hBBBB);
    chk("R3 refill read", cmds[1], 0);
    chk("R3 refill data", rd, 16'hA514);
    snoop(2'd0, 8'h10, 0, sh, sp, sd);
    chk("R9 victim invalid", sh, 0);
    snoop(2'd0, 8'h14, 0, sh, sp, sd);
    chk("R3 shared fill hit", sh, 1);
    chk("R3 shared no supply", sp, 0);
  endtask

  task automatic t_upgrade;
    do_op(1, 8'h14, 16'h3333, 0, 0, rd);
    chk("R4 S write txn", ncmd, 1);
    chk("R4 S write invalidate", cmds[0], 2);
    snoop(2'd1, 8'h14, 0, sh, sp, sd);
    chk("R7 M supplies on probe write", sp, 1);
    chk("R7 supplied data", sd, 16'h3333);
    snoop(2'd0, 8'h14, 0, sh, sp, sd);
    chk("R7 invalid after probe write", sh, 0);
  endtask

  task automatic t_probe_write_clean;
    do_op(0, 8'h21, 0, 0, 0, rd);
    snoop(2'd1, 8'h21, 0, sh, sp, sd);
    chk("R7 clean hit seen", sh, 1);
    chk("R7 clean no supply", sp, 0);
    do_op(0, 8'h21, 0, 0, 0, rd);
    chk("R7 re-read misses", ncmd, 1);
    chk("R7 re-read cmd", cmds[0], 0);
  endtask

  task automatic t_update;
    do_op(0, 8'h22, 0, 1, 0, rd);
    snoop(2'd2, 8'h22, 16'h5555, sh, sp, sd);
    chk("R8 update no supply", sp, 0);
    do_op(0, 8'h22, 0, 0, 0, rd);
    chk("R8 still hit", ncmd, 0);
    chk("R8 updated word", rd, 16'h5555);
  endtask

  task automatic t_write_miss;
    do_op(1, 8'h23, 16'h7777, 0, 0, rd);
    chk("R4 miss txn", ncmd, 1);
    chk("R4 miss rfo", cmds[0], 1);
    do_op(0, 8'h23, 0, 0, 0, rd);
    chk("R4 rfo word kept", rd, 16'h7777);
    chk("R4 rfo then hit", ncmd, 0);
    snoop(2'd0, 8'h23, 0, sh, sp, sd);
    chk("R4 ends modified supply", sp, 1);
  endtask

  task automatic t_exclusive_snoop;
    do_op(0, 8'h31, 0, 0, 0, rd);
    chk("R9 clean victim no write-back", ncmd, 1);
    chk("R9 clean victim read only", cmds[0], 0);
    snoop(2'd0, 8'h31, 0, sh, sp, sd);
    chk("R6 E shared", sh, 1);
    chk("R6 E no supply", sp, 0);
    do_op(1, 8'h31, 16'hCCCC, 0, 0, rd);
    chk("R6 E became S", cmds[0], 2);
  endtask

  task automatic t_stall;
    do_op(1, 8'h02, 16'h9999, 0, 3, rd);
    chk("R10 one txn", ncmd, 1);
    chk("R10 completes at grant", ncyc, 4);
    do_op(0, 8'h06, 0, 0, 2, rd);
    chk("R10 delayed read txns", ncmd, 2);
    chk("R10 delayed read cycles", ncyc, 7);
    chk("R10 delayed read data", rd, 16'hA506);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'hA5, i[7:0]};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_exclusive();
    t_owned();
    t_evict_owned();
    t_upgrade();
    t_probe_write_clean();
    t_update();
    t_write_miss();
    t_exclusive_snoop();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule